// File: doc/BRIEF.md
# Variable-Length Instruction Length Decoder

This block sits at the front of an instruction pipeline and receives the instruction stream one byte per cycle. An input valid strobe qualifies each byte. From the leading byte it works out the instruction's category, its operand size and which bytes follow. The next byte can be a register/mode byte, a displacement, a 24-bit address or the sub-opcode. For the categories that may carry an immediate, the sub-opcode byte sets how many immediate bytes come after it. The decoder therefore learns the final length only once that byte has arrived. When the last byte of an instruction has been taken, the block raises a one-cycle done strobe. At the same time it presents the total length and the decoded fields: register, sub-opcode, sign-extended displacement, address and little-endian immediate. These stay held until the next instruction completes.

The sequencer has six states:
- ST_FIRST takes the leading byte.
- ST_RBYTE takes a register/mode byte.
- ST_ADDR takes the three address bytes.
- ST_DISP takes one or two displacement bytes.
- ST_SUB takes the sub-opcode.
- ST_IMM takes the immediate bytes.

Its transitions run as follows:
- ST_FIRST goes to one of ST_RBYTE, ST_ADDR, ST_DISP, ST_SUB or ST_IMM, depending on the leading byte.
- ST_RBYTE goes to ST_DISP or ST_SUB.
- ST_ADDR and ST_DISP go to ST_SUB after their last byte.
- ST_SUB goes to ST_IMM when an immediate follows. Otherwise it completes.
- ST_IMM completes after its last byte.
- Every completion returns to ST_FIRST, as does an illegal leading byte.
- A cycle with the valid strobe low leaves every state and held field untouched.

Top module: `ild_top`

## Requirements
- R1: While reset is asserted, and until the first completion after it, o_done, o_illegal, o_len and o_cat are all 0.
- R2: A cycle with in_valid low consumes no byte. The sequencer state and the held results do not change.
- R3: Leading bytes 0x40–0x47 complete after 5 bytes with category 1 (o_cat=1) and size 32 (o_size=3). The register is byte&7, o_subop is 0, and o_imm holds bytes 2–5 little-endian.
- R4: Leading bytes 0xC8–0xCF, 0xD8–0xDF and 0xE8–0xEF give category 2 with size 8/16/32 (o_size 1/2/3). The register is the low 3 bits and o_subop is byte 2. When byte 2 takes no immediate, the length is 2.
- R5: In category 2, sub-opcodes 0x03 and 0xC8–0xCF are followed by an immediate of 1, 2 or 4 bytes for size 8, 16 or 32. It is assembled little-endian into o_imm, giving lengths 3, 4 and 6.
- R6: In category 2, sub-opcodes 0xE8–0xEF, 0x30, 0x31 and 0x33 are followed by one count/bit byte in o_imm, for a length of 3, whatever the size.
- R7: Leading bytes 0x80–0xB7 give category 3 with o_imm=0 and address register byte&7. The displacement depends on the byte:
  - 0x80/0x90/0xA0+R (sizes 8/16/32) carry none and have length 2.
  - 0x88/0x98/0xA8+R carry one byte, sign-extended to 16 bits in o_disp, and have length 3.
  - 0xB0+R (size 32) carries two bytes, low first, and has length 4.
  
  o_subop is the last byte.
- R8: Leading bytes 0xB8–0xBF give category 4 with size code 0. Byte 2 is a sign-extended displacement and byte 3 is o_subop. Sub-opcode 0x00 adds a 1-byte immediate and 0x02 a 2-byte little-endian immediate. Any other sub-opcode adds none.
- R9: Leading bytes 0xC0–0xC5, 0xD0–0xD5, 0xE0–0xE5 and 0xF0–0xF5 give category 5, and their low 3 bits select the mode:
  - Modes 0, 4 and 5 have length 3.
  - Mode 1 has length 4 and carries a sign-extended d8 as byte 3.
  - Mode 2 has length 5 and carries a 24-bit little-endian address in bytes 2–4.
  - Mode 3 has length 5 and carries a little-endian d16 in bytes 3–4.
  
  The register is bits 4:2 of byte 2, or 0 in mode 2. o_size is 1/2/3 for the 0xC/0xD/0xE rows and 0 for the 0xF row, and o_subop is the last byte.
- R10: Leading byte 0xD7 gives category 6 with o_size=2. The register is bits 4:2 of byte 2 and o_subop is byte 3. The immediate follows the rules of R5 and R6 at size 16.
- R11: Every other leading byte gives a one-byte result with o_illegal=1, o_cat=0 and o_len=1. The next byte is taken as a new leading byte.
- R12: o_done is high for exactly the cycle after the last byte of an instruction is taken. All result outputs hold their values between completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Current byte is present and is taken this cycle |
| in_byte | input | 8 | Instruction stream byte |
| o_done | output | 1 | One-cycle completion strobe |
| o_illegal | output | 1 | Completed result was an unknown leading byte |
| o_cat | output | 3 | Category code (0 illegal, 1–6 as in the requirements) |
| o_size | output | 2 | Operand size code: 0 none, 1 8-bit, 2 16-bit, 3 32-bit |
| o_reg | output | 3 | Register or address-register field |
| o_subop | output | 8 | Sub-opcode byte |
| o_len | output | 3 | Total instruction length in bytes |
| o_disp | output | 16 | Displacement, d8 sign-extended |
| o_addr | output | 24 | Direct 24-bit address |
| o_imm | output | 32 | Immediate, little-endian, zero-extended |

## Verification
The assertions assume that in_valid and in_byte are never X once reset is released. They also assume the stream starts on an instruction boundary after reset, so the first byte taken is always treated as a leading byte. The bench drives both inputs only on the falling edge and always from a known stream. The stream is a fixed list of instructions covering every category, every immediate size and every displacement form, interleaved with unknown leading bytes. It is sent once back to back and once with gaps of one and two idle cycles inside instructions, so stalls land in every sequencer state.

// File: rtl/ild_pkg.sv
package ild_pkg;

    localparam int BYTE_W     = 8;
    localparam int IMM_W      = 32;
    localparam int DISP_W     = 16;
    localparam int ADDR_W     = 24;
    localparam int LEN_W      = 3;
    localparam int IMM_BYTES  = IMM_W / BYTE_W;
    localparam int ADDR_BYTES = ADDR_W / BYTE_W;
    localparam int DISP_BYTES = DISP_W / BYTE_W;
    localparam int CNT_W      = $clog2(IMM_BYTES + 1);

    typedef enum logic [2:0] {
        CAT_BAD   = 3'd0,
        CAT_K32   = 3'd1,
        CAT_RSRC  = 3'd2,
        CAT_MSRC  = 3'd3,
        CAT_MDST  = 3'd4,
        CAT_EXT   = 3'd5,
        CAT_PBANK = 3'd6
    } cat_e;

    typedef enum logic [1:0] {
        SZ_NONE = 2'd0,
        SZ_8    = 2'd1,
        SZ_16   = 2'd2,
        SZ_32   = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        IR_NONE = 2'd0,
        IR_REG  = 2'd1,
        IR_DST  = 2'd2,
        IR_FIX4 = 2'd3
    } immr_e;

    typedef struct packed {
        cat_e        cat;
        size_e       size;
        logic [2:0]  reg_f;
        logic        need_rb;
        logic [1:0]  n_disp;
        logic        use_addr;
        immr_e       immr;
    } plan_t;

    function automatic int size_bytes(size_e s);
        case (s)
            SZ_8:    return 1;
            SZ_16:   return 2;
            SZ_32:   return IMM_BYTES;
            default: return 0;
        endcase
    endfunction

    function automatic size_e row_size(logic [1:0] row);
        case (row)
            2'b00:   return SZ_8;
            2'b01:   return SZ_16;
            2'b10:   return SZ_32;
            default: return SZ_NONE;
        endcase
    endfunction

endpackage

// File: rtl/ild_classify.sv
module ild_classify
    import ild_pkg::*;
(
    input  logic [BYTE_W-1:0] lead,
    output plan_t             plan
);

    always_comb begin
        plan       = '0;
        plan.cat   = CAT_BAD;
        plan.size  = SZ_NONE;
        plan.immr  = IR_NONE;
        unique case (lead[7:6])
            2'b00: begin
                plan.cat = CAT_BAD;
            end
            2'b01: begin
                if (lead[5:3] == 3'b000) begin
                    plan.cat   = CAT_K32;
                    plan.size  = SZ_32;
                    plan.reg_f = lead[2:0];
                    plan.immr  = IR_FIX4;
                end
            end
            2'b10: begin
                plan.reg_f = lead[2:0];
                plan.cat   = CAT_MSRC;
                unique case (lead[5:3])
                    3'b000: plan.size = SZ_8;
                    3'b001: begin plan.size = SZ_8;  plan.n_disp = 2'd1; end
                    3'b010: plan.size = SZ_16;
                    3'b011: begin plan.size = SZ_16; plan.n_disp = 2'd1; end
                    3'b100: plan.size = SZ_32;
                    3'b101: begin plan.size = SZ_32; plan.n_disp = 2'd1; end
                    3'b110: begin plan.size = SZ_32; plan.n_disp = 2'd2; end
                    3'b111: begin
                        plan.cat    = CAT_MDST;
                        plan.n_disp = 2'd1;
                        plan.immr   = IR_DST;
                    end
                endcase
            end
            2'b11: begin
                if (lead == 8'hD7) begin
                    plan.cat     = CAT_PBANK;
                    plan.size    = SZ_16;
                    plan.need_rb = 1'b1;
                    plan.immr    = IR_REG;
                end else if (lead[3]) begin
                    if (lead[5:4] != 2'b11) begin
                        plan.cat   = CAT_RSRC;
                        plan.size  = row_size(lead[5:4]);
                        plan.reg_f = lead[2:0];
                        plan.immr  = IR_REG;
                    end
                end else begin
                    plan.cat  = CAT_EXT;
                    plan.size = row_size(lead[5:4]);
                    unique case (lead[2:0])
                        3'd0, 3'd4, 3'd5: plan.need_rb = 1'b1;
                        3'd1: begin plan.need_rb = 1'b1; plan.n_disp = 2'd1; end
                        3'd2: plan.use_addr = 1'b1;
                        3'd3: begin plan.need_rb = 1'b1; plan.n_disp = 2'd2; end
                        default: begin
                            plan.cat  = CAT_BAD;
                            plan.size = SZ_NONE;
                        end
                    endcase
                end
            end
        endcase
    end

endmodule

// File: rtl/ild_imm_size.sv
module ild_imm_size
    import ild_pkg::*;
(
    input  immr_e              rule,
    input  size_e              size,
    input  logic [BYTE_W-1:0]  sub,
    output logic [CNT_W-1:0]   nimm
);

    always_comb begin
        nimm = '0;
        unique case (rule)
            IR_REG: begin
                if (sub == 8'h03 || sub[7:3] == 5'b11001)
                    nimm = CNT_W'(size_bytes(size));
                else if (sub[7:3] == 5'b11101 || sub == 8'h30 ||
                         sub == 8'h31 || sub == 8'h33)
                    nimm = CNT_W'(1);
            end
            IR_DST: begin
                if (sub == 8'h00)
                    nimm = CNT_W'(1);
                else if (sub == 8'h02)
                    nimm = CNT_W'(2);
            end
            IR_FIX4: nimm = CNT_W'(IMM_BYTES);
            IR_NONE: nimm = '0;
        endcase
    end

endmodule

// File: rtl/ild_core.sv
module ild_core
    import ild_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [BYTE_W-1:0]  in_byte,
    input  plan_t              plan_in,
    input  logic [CNT_W-1:0]   nimm_in,
    output plan_t              plan_q,
    output logic               o_done,
    output logic               o_illegal,
    output logic [2:0]         o_cat,
    output logic [1:0]         o_size,
    output logic [2:0]         o_reg,
    output logic [BYTE_W-1:0]  o_subop,
    output logic [LEN_W-1:0]   o_len,
    output logic [DISP_W-1:0]  o_disp,
    output logic [ADDR_W-1:0]  o_addr,
    output logic [IMM_W-1:0]   o_imm
);

    typedef enum logic [2:0] {
        ST_FIRST, ST_RBYTE, ST_ADDR, ST_DISP, ST_SUB, ST_IMM
    } st_e;

    st_e                 state, st_n;
    plan_t               p_n;
    logic [CNT_W-1:0]    fcnt, fcnt_n, fnum, fnum_n;
    logic [2:0]          w_reg, wreg_n;
    logic [BYTE_W-1:0]   w_sub, wsub_n;
    logic [DISP_W-1:0]   w_disp, wdisp_n;
    logic [ADDR_W-1:0]   w_addr, waddr_n;
    logic [IMM_W-1:0]    w_imm, wimm_n;
    logic [LEN_W-1:0]    w_len, wlen_n;
    logic                fin, ill, last;

    assign last = (fcnt + CNT_W'(1) == fnum);

    always_comb begin
        st_n    = state;
        p_n     = plan_q;
        fcnt_n  = fcnt;
        fnum_n  = fnum;
        wreg_n  = w_reg;
        wsub_n  = w_sub;
        wdisp_n = w_disp;
        waddr_n = w_addr;
        wimm_n  = w_imm;
        wlen_n  = w_len;
        fin     = 1'b0;
        ill     = 1'b0;
        if (in_valid) begin
            wlen_n = w_len + LEN_W'(1);
            fcnt_n = fcnt + CNT_W'(1);
            unique case (state)
                ST_FIRST: begin
                    p_n     = plan_in;
                    wlen_n  = LEN_W'(1);
                    wreg_n  = plan_in.reg_f;
                    wsub_n  = '0;
                    wdisp_n = '0;
                    waddr_n = '0;
                    wimm_n  = '0;
                    fcnt_n  = '0;
                    if (plan_in.cat == CAT_BAD) begin
                        fin = 1'b1;
                        ill = 1'b1;
                    end else if (plan_in.immr == IR_FIX4) begin
                        st_n   = ST_IMM;
                        fnum_n = CNT_W'(IMM_BYTES);
                    end else if (plan_in.need_rb) begin
                        st_n = ST_RBYTE;
                    end else if (plan_in.use_addr) begin
                        st_n   = ST_ADDR;
                        fnum_n = CNT_W'(ADDR_BYTES);
                    end else if (plan_in.n_disp != 2'd0) begin
                        st_n   = ST_DISP;
                        fnum_n = CNT_W'(plan_in.n_disp);
                    end else begin
                        st_n = ST_SUB;
                    end
                end
                ST_RBYTE: begin
                    wreg_n = in_byte[4:2];
                    fcnt_n = '0;
                    if (plan_q.n_disp != 2'd0) begin
                        st_n   = ST_DISP;
                        fnum_n = CNT_W'(plan_q.n_disp);
                    end else begin
                        st_n = ST_SUB;
                    end
                end
                ST_ADDR: begin
                    waddr_n[int'(fcnt)*BYTE_W +: BYTE_W] = in_byte;
                    if (last) st_n = ST_SUB;
                end
                ST_DISP: begin
                    if (plan_q.n_disp == 2'd1)
                        wdisp_n = {{(DISP_W-BYTE_W){in_byte[BYTE_W-1]}}, in_byte};
                    else
                        wdisp_n[int'(fcnt)*BYTE_W +: BYTE_W] = in_byte;
                    if (last) st_n = ST_SUB;
                end
                ST_SUB: begin
                    wsub_n = in_byte;
                    fcnt_n = '0;
                    if (nimm_in != '0) begin
                        st_n   = ST_IMM;
                        fnum_n = nimm_in;
                    end else begin
                        fin = 1'b1;
                    end
                end
                ST_IMM: begin
                    wimm_n[int'(fcnt)*BYTE_W +: BYTE_W] = in_byte;
                    if (last) fin = 1'b1;
                end
                default: st_n = ST_FIRST;
            endcase
            if (fin) st_n = ST_FIRST;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_FIRST;
            plan_q <= '0;
            fcnt   <= '0;
            fnum   <= '0;
            w_reg  <= '0;
            w_sub  <= '0;
            w_disp <= '0;
            w_addr <= '0;
            w_imm  <= '0;
            w_len  <= '0;
        end else begin
            state  <= st_n;
            plan_q <= p_n;
            fcnt   <= fcnt_n;
            fnum   <= fnum_n;
            w_reg  <= wreg_n;
            w_sub  <= wsub_n;
            w_disp <= wdisp_n;
            w_addr <= waddr_n;
            w_imm  <= wimm_n;
            w_len  <= wlen_n;
        end
    end

    // result outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_done    <= 1'b0;
            o_illegal <= 1'b0;
            o_cat     <= '0;
            o_size    <= '0;
            o_reg     <= '0;
            o_subop   <= '0;
            o_len     <= '0;
            o_disp    <= '0;
            o_addr    <= '0;
            o_imm     <= '0;
        end else begin
            o_done <= fin;
            if (fin) begin
                o_illegal <= ill;
                o_cat     <= p_n.cat;
                o_size    <= p_n.size;
                o_reg     <= wreg_n;
                o_subop   <= wsub_n;
                o_len     <= wlen_n;
                o_disp    <= wdisp_n;
                o_addr    <= waddr_n;
                o_imm     <= wimm_n;
            end
        end
    end

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(state) && $stable(w_len)) else $error("stall moved state"); // R2
    AST_K32_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (o_done && o_cat == CAT_K32) |-> o_len == LEN_W'(5)) else $error("bad k32 length"); // R3
    AST_MSRC_NO_IMM: assert property (@(posedge clk) disable iff (!rst_n)
        (o_done && o_cat == CAT_MSRC) |-> o_imm == '0) else $error("memsrc immediate"); // R7
    AST_EXT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (o_done && o_cat == CAT_EXT) |-> (o_len >= LEN_W'(3) && o_len <= LEN_W'(5))) else $error("ext length"); // R9
    AST_ILLEGAL_ONE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (o_done && o_illegal) |-> (o_len == LEN_W'(1) && o_cat == CAT_BAD)) else $error("illegal length"); // R11
    AST_DONE_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        o_done |-> $past(in_valid)) else $error("done without byte"); // R12
    AST_RESULTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !o_done |-> ($stable(o_len) && $stable(o_imm) && $stable(o_subop))) else $error("results moved"); // R12

endmodule

// File: rtl/ild_top.sv
module ild_top
    import ild_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [7:0]         in_byte,
    output logic               o_done,
    output logic               o_illegal,
    output logic [2:0]         o_cat,
    output logic [1:0]         o_size,
    output logic [2:0]         o_reg,
    output logic [7:0]         o_subop,
    output logic [2:0]         o_len,
    output logic [15:0]        o_disp,
    output logic [23:0]        o_addr,
    output logic [31:0]        o_imm
);

    plan_t             plan_lead;
    plan_t             plan_held;
    logic [CNT_W-1:0]  nimm;

    ild_classify u_classify (
        .lead (in_byte),
        .plan (plan_lead)
    );

    ild_imm_size u_imm_size (
        .rule (plan_held.immr),
        .size (plan_held.size),
        .sub  (in_byte),
        .nimm (nimm)
    );

    ild_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_byte   (in_byte),
        .plan_in   (plan_lead),
        .nimm_in   (nimm),
        .plan_q    (plan_held),
        .o_done    (o_done),
        .o_illegal (o_illegal),
        .o_cat     (o_cat),
        .o_size    (o_size),
        .o_reg     (o_reg),
        .o_subop   (o_subop),
        .o_len     (o_len),
        .o_disp    (o_disp),
        .o_addr    (o_addr),
        .o_imm     (o_imm)
    );

endmodule

// File: tb/test_ild_top.sv
module test_ild_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        o_done, o_illegal;
    logic [2:0]  o_cat, o_reg, o_len;
    logic [1:0]  o_size;
    logic [7:0]  o_subop;
    logic [15:0] o_disp;
    logic [23:0] o_addr;
    logic [31:0] o_imm;

    always #5 clk = ~clk;

    ild_top i_ild_top (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .o_done(o_done), .o_illegal(o_illegal), .o_cat(o_cat), .o_size(o_size),
        .o_reg(o_reg), .o_subop(o_subop), .o_len(o_len), .o_disp(o_disp),
        .o_addr(o_addr), .o_imm(o_imm)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit ended   = 1'b0;

    logic [7:0] s_byte[$];
    string      s_tag[$];
    string      drv_tag = "";
    bit         stalled_prev = 1'b0;

    task automatic add(string tag, int n, logic [55:0] v);
        for (int i = 0; i < n; i++) begin
            s_byte.push_back(v[8*(n-1-i) +: 8]);
            s_tag.push_back(tag);
        end
    endtask

    task automatic chk(string req, string what, logic [63:0] got, logic [63:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // behavioural reference model
    logic [7:0]  mq[$];
    string       m_tag = "";
    logic        e_done = 0, e_ill = 0;
    logic [2:0]  e_cat = 0, e_reg = 0, e_len = 0;
    logic [1:0]  e_size = 0;
    logic [7:0]  e_sub = 0;
    logic [15:0] e_disp = 0;
    logic [23:0] e_addr = 0;
    logic [31:0] e_imm = 0;
    string       e_tag = "";

    function automatic int row_bytes(logic [7:0] b);
        if (b[7:4] == 4'hC) return 1;
        if (b[7:4] == 4'hD) return 2;
        return 4;
    endfunction

    function automatic int imm_after(logic [7:0] s, int szb);
        if (s == 8'h03 || (s >= 8'hC8 && s <= 8'hCF)) return szb;
        if ((s >= 8'hE8 && s <= 8'hEF) || s == 8'h30 || s == 8'h31 || s == 8'h33) return 1;
        return 0;
    endfunction

    function automatic bit is_rsrc(logic [7:0] b);
        return (b >= 8'hC8 && b <= 8'hCF) || (b >= 8'hD8 && b <= 8'hDF) ||
               (b >= 8'hE8 && b <= 8'hEF);
    endfunction

    function automatic bit is_ext(logic [7:0] b);
        return b >= 8'hC0 && b[3] == 1'b0 && b[2:0] <= 3'd5;
    endfunction

    function automatic int need();
        logic [7:0] b0;
        int n;
        n = mq.size();
        if (n == 0) return 0;
        b0 = mq[0];
        if (b0 >= 8'h40 && b0 <= 8'h47) return 5;
        if (is_rsrc(b0)) return (n < 2) ? 0 : 2 + imm_after(mq[1], row_bytes(b0));
        if (b0 >= 8'h80 && b0 <= 8'hB7) begin
            if (b0 >= 8'hB0) return 4;
            return (b0[3]) ? 3 : 2;
        end
        if (b0 >= 8'hB8 && b0 <= 8'hBF) begin
            if (n < 3) return 0;
            return 3 + ((mq[2] == 8'h00) ? 1 : (mq[2] == 8'h02) ? 2 : 0);
        end
        if (b0 == 8'hD7) return (n < 3) ? 0 : 3 + imm_after(mq[2], 2);
        if (is_ext(b0)) begin
            case (b0[2:0])
                3'd1: return 4;
                3'd2, 3'd3: return 5;
                default: return 3;
            endcase
        end
        return 1;
    endfunction

    function automatic logic [31:0] le(int start, int cnt);
        logic [31:0] r = 0;
        for (int i = 0; i < cnt; i++) r[8*i +: 8] = mq[start+i];
        return r;
    endfunction

    function automatic logic [15:0] sx(logic [7:0] b);
        return {{8{b[7]}}, b};
    endfunction

    task automatic decode();
        logic [7:0] b0;
        int n;
        b0 = mq[0];
        n  = mq.size();
        e_len = 3'(n); e_ill = 0; e_cat = 0; e_size = 0; e_reg = 0;
        e_sub = 0; e_disp = 0; e_addr = 0; e_imm = 0;
        if (b0 >= 8'h40 && b0 <= 8'h47) begin
            e_cat = 1; e_size = 3; e_reg = b0[2:0]; e_imm = le(1, 4);
        end else if (is_rsrc(b0)) begin
            e_cat = 2; e_size = 2'(b0[7:4] - 4'hB); e_reg = b0[2:0];
            e_sub = mq[1]; e_imm = le(2, n - 2);
        end else if (b0 >= 8'h80 && b0 <= 8'hB7) begin
            e_cat = 3; e_reg = b0[2:0]; e_sub = mq[n-1];
            e_size = (b0 < 8'h90) ? 2'd1 : (b0 < 8'hA0) ? 2'd2 : 2'd3;
            if (b0 >= 8'hB0) e_disp = {mq[2], mq[1]};
            else if (b0[3]) e_disp = sx(mq[1]);
        end else if (b0 >= 8'hB8 && b0 <= 8'hBF) begin
            e_cat = 4; e_reg = b0[2:0]; e_disp = sx(mq[1]); e_sub = mq[2];
            e_imm = le(3, n - 3);
        end else if (b0 == 8'hD7) begin
            e_cat = 6; e_size = 2; e_reg = mq[1][4:2]; e_sub = mq[2];
            e_imm = le(3, n - 3);
        end else if (is_ext(b0)) begin
            e_cat = 5; e_sub = mq[n-1];
            e_size = (b0[7:4] == 4'hF) ? 2'd0 : 2'(b0[7:4] - 4'hB);
            e_reg = (b0[2:0] == 3'd2) ? 3'd0 : mq[1][4:2];
            if (b0[2:0] == 3'd1) e_disp = sx(mq[2]);
            if (b0[2:0] == 3'd3) e_disp = {mq[3], mq[2]};
            if (b0[2:0] == 3'd2) e_addr = {mq[3], mq[2], mq[1]};
        end else begin
            e_ill = 1;
        end
    endtask

    always @(posedge clk) begin
        if (rst_n) begin
            e_done = 0;
            if (in_valid) begin
                if (mq.size() == 0) m_tag = drv_tag;
                mq.push_back(in_byte);
                if (need() != 0 && mq.size() == need()) begin
                    decode();
                    e_done = 1;
                    e_tag  = m_tag;
                    mq.delete();
                end
            end
        end
    end

    task automatic compare();
        chk(stalled_prev ? "R2" : "R12", "done", 64'(o_done), 64'(e_done));
        if (e_done) begin
            chk(e_tag, "illegal", 64'(o_illegal), 64'(e_ill));
            chk(e_tag, "cat",     64'(o_cat),     64'(e_cat));
            chk(e_tag, "size",    64'(o_size),    64'(e_size));
            chk(e_tag, "reg",     64'(o_reg),     64'(e_reg));
            chk(e_tag, "subop",   64'(o_subop),   64'(e_sub));
            chk(e_tag, "len",     64'(o_len),     64'(e_len));
            chk(e_tag, "disp",    64'(o_disp),    64'(e_disp));
            chk(e_tag, "addr",    64'(o_addr),    64'(e_addr));
            chk(e_tag, "imm",     64'(o_imm),     64'(e_imm));
        end
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            finish_run();
        end
    end

    initial begin
        add("R3", 5, 56'h41_7F_00_E0_01);
        add("R3", 5, 56'h47_EF_BE_AD_DE);
        add("R4", 2, 56'hC9_A3);
        add("R4", 2, 56'hDC_22);
        add("R4", 2, 56'hEB_80);
        add("R5", 3, 56'hCA_C8_5A);
        add("R5", 4, 56'hDB_03_34_12);
        add("R5", 6, 56'hEE_CC_78_56_34_12);
        add("R6", 3, 56'hD8_E8_03);
        add("R6", 3, 56'hDA_31_0F);
        add("R6", 3, 56'hCA_EF_02);
        add("R6", 3, 56'hE9_33_1F);
        add("R7", 2, 56'h82_21);
        add("R7", 3, 56'h9D_C8_21);
        add("R7", 3, 56'hA8_05_80);
        add("R7", 4, 56'hB3_34_12_88);
        add("R8", 3, 56'hBA_10_30);
        add("R8", 4, 56'hBC_F0_00_AA);
        add("R8", 5, 56'hBF_04_02_CD_AB);
        add("R9", 3, 56'hC0_E4_21);
        add("R9", 4, 56'hD1_E8_FE_88);
        add("R9", 5, 56'hE2_56_34_12_20);
        add("R9", 5, 56'hF3_F0_00_80_60);
        add("R9", 3, 56'hC4_EC_23);
        add("R9", 3, 56'hE5_FC_22);
        add("R10", 5, 56'hD7_E6_C8_11_22);
        add("R10", 4, 56'hD7_FA_E8_04);
        add("R10", 3, 56'hD7_E2_20);
        add("R11", 1, 56'h00);
        add("R11", 1, 56'hFF);
        add("R11", 1, 56'hC6);
        add("R11", 1, 56'h7F);
        add("R11", 1, 56'hE6);
        add("R11", 1, 56'hF7);
        add("R4", 2, 56'hCF_A0);

        repeat (3) @(negedge clk);
        chk("R1", "reset done",    64'(o_done),    64'd0);
        chk("R1", "reset illegal", 64'(o_illegal), 64'd0);
        chk("R1", "reset len",     64'(o_len),     64'd0);
        chk("R1", "reset cat",     64'(o_cat),     64'd0);
        rst_n = 1'b1;

        for (int pass = 0; pass < 2; pass++) begin
            for (int k = 0; k < s_byte.size(); k++) begin
                int gaps;
                gaps = 0;
                if (pass == 1) gaps = (k % 3 == 1) ? 1 : ((k % 7 == 0) ? 2 : 0);
                for (int g = 0; g < gaps; g++) begin
                    @(negedge clk);
                    compare();
                    stalled_prev = 1'b1;
                    in_valid = 1'b0;
                    in_byte  = 8'hC8;
                end
                @(negedge clk);
                compare();
                stalled_prev = (gaps != 0);
                in_valid = 1'b1;
                in_byte  = s_byte[k];
                drv_tag  = s_tag[k];
            end
        end
        for (int t = 0; t < 4; t++) begin
            @(negedge clk);
            compare();
            stalled_prev = (t != 0);
            in_valid = 1'b0;
        end
        finish_run();
    end

endmodule